// File: doc/BRIEF.md
# Reset and Wake-Up Sequencer

This controller decides when the internal reset is released and when system clocks are turned on. It acts after a power-on event, a low-voltage event, a long enough external reset request, or a wake from one of three low-power states: stop, pseudo stop and doze. The oscillator and the regulator are not modelled as analog parts. The oscillator appears as a pulse for each detected oscillator edge. The regulator appears as a level that says it is back at full performance.

Each cause takes its own recovery path. A power-on or low-voltage reset runs a clock quality check and then a fixed startup delay, with the internal reset held the whole time. A qualified external reset skips the check if the oscillator was already proven stable. A wake from stop waits for the regulator and then runs the check. A wake from pseudo stop waits for the regulator only. A wake from doze resumes at once. If the check does not find a valid oscillation before its timeout, the clock select moves to the internal self clock and the sequence goes on. A power-on flag lets software judge whether memory contents survived.

Top module: `rst_wake_seq`

## Requirements
- R1: After the asynchronous reset, or on a `por_pulse` or `lvr_pulse`, the state becomes clock check. `rst_int` is 1 and `clk_en` is 0 until the sequence ends.
- R2: If the clock check sees no valid oscillation within `cfg_tmo` cycles (counted from its first cycle), it ends after exactly `cfg_tmo` cycles. `clk_sel_self` then becomes 1 and the sequence continues. A later passing check sets `clk_sel_self` back to 0.
- R3: An external request `ext_rst_req` that is high for 2 or more consecutive cycles starts an internal reset. A 1-cycle pulse has no effect.
- R4: A qualified external reset goes straight to the startup delay, with no check cycle, if the last clock check passed and no power-on, low-voltage or stop event has happened since. Otherwise it runs the clock check first.
- R5: A wake from stop waits in regulator wait until `vreg_fpm` is 1. It then runs a clock check and enters run. `rst_int` stays 0 on this path.
- R6: A wake from pseudo stop waits in regulator wait until `vreg_fpm` is 1 and then enters run in the next cycle, with no clock check.
- R7: A wake from doze enters run in the cycle right after the wake input.
- R8: The startup delay state lasts exactly 194 cycles. During it `rst_int` is 1 and `clk_en` is 1. `rst_int` falls when run begins.
- R9: `por_flag` is set by `por_pulse` (and by the asynchronous reset) and cleared by `por_clr`. Low-voltage and external resets leave it unchanged.
- R10: The clock check passes in the cycle of the `cfg_edges`-th `osc_tick`. A gap of more than 7 cycles without a tick restarts the edge count.
- R11: `lp_req` with `lp_sel` = 1 (stop), 2 (pseudo stop) or 3 (doze) is accepted only in run. Wake sources are:
  - stop: `irq_ext` or `wake_tmr`;
  - pseudo stop: `irq_ext`, `wake_tmr` or `irq_int`;
  - doze: `irq_ext` or `irq_int`.
  Wake inputs are ignored in every other state.
- R12: A reset cause has priority over a wake in the same cycle. `state_oh` bits are 0 run, 1 clock check, 2 startup, 3 regulator wait, 4 stop, 5 pseudo stop, 6 doze. `seq_done` is 1 for the first run cycle after any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| por_pulse | input | 1 | Power-on reset cause |
| lvr_pulse | input | 1 | Low-voltage reset cause |
| ext_rst_req | input | 1 | External reset request level |
| osc_tick | input | 1 | One pulse for each detected oscillator edge |
| vreg_fpm | input | 1 | Regulator at full performance |
| lp_req | input | 1 | Low-power entry request |
| lp_sel | input | 2 | Low-power mode: 1 stop, 2 pseudo stop, 3 doze |
| irq_ext | input | 1 | External interrupt wake |
| irq_int | input | 1 | Internal interrupt wake |
| wake_tmr | input | 1 | Periodic wake timer |
| por_clr | input | 1 | Clears the power-on flag |
| cfg_edges | input | 8 | Edge count needed to pass the clock check |
| cfg_tmo | input | 16 | Clock check timeout in cycles |
| rst_int | output | 1 | Internal reset, active high |
| clk_en | output | 1 | System clock enable |
| clk_sel_self | output | 1 | 1 selects the internal self clock |
| por_flag | output | 1 | Power-on flag |
| state_oh | output | 7 | One-hot sequencer state |
| seq_done | output | 1 | Pulse in the first run cycle after a sequence |

## Verification
The function pair that can fall in the same cycle is a reset cause and a low-power wake. The bench puts the block in stop and then raises `irq_ext` and `lvr_pulse` on the same edge. It judges the result by checking that the next state is clock check rather than regulator wait, with `rst_int` high. It then checks that the full startup delay follows. A second overlap is a wake that arrives during regulator wait; the bench checks that it leaves the state unchanged.

// File: rtl/rws_pkg.sv
package rws_pkg;
  localparam int NUM_ST = 7;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_CQ    = 3'd1,
    ST_SU    = 3'd2,
    ST_VREG  = 3'd3,
    ST_STOP  = 3'd4,
    ST_PSTOP = 3'd5,
    ST_DOZE  = 3'd6
  } seq_st_e;

  localparam logic [1:0] LP_STOP  = 2'd1;
  localparam logic [1:0] LP_PSTOP = 2'd2;
  localparam logic [1:0] LP_DOZE  = 2'd3;
endpackage

// File: rtl/rws_ext_filter.sv
module rws_ext_filter #(
  parameter int EXT_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic qual
);
  localparam int CW = $clog2(EXT_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(EXT_MIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!req)              cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qual = req && (cnt_q == LAST);

  // R3: a qualification needs the request seen in the previous cycle too
  p_ext_min_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(req));
endmodule

// File: rtl/rws_clk_check.sv
module rws_clk_check #(
  parameter int EDGE_W  = 8,
  parameter int TMO_W   = 16,
  parameter int GAP_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              osc_tick,
  input  logic [EDGE_W-1:0] cfg_edges,
  input  logic [TMO_W-1:0]  cfg_tmo,
  output logic              pass,
  output logic              fail
);
  localparam int GW = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_MAX - 1);

  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [GW-1:0]     gap_q, gap_d;

  always_comb begin
    edge_d = edge_q;
    tmo_d  = tmo_q + 1'b1;
    gap_d  = gap_q;
    if (osc_tick) begin
      edge_d = edge_q + 1'b1;
      gap_d  = '0;
    end else begin
      if (gap_q == GAP_LAST) edge_d = '0;
      if (gap_q != GW'(GAP_MAX)) gap_d = gap_q + 1'b1;
    end
    if (clr) begin
      edge_d = '0;
      tmo_d  = '0;
      gap_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      tmo_q  <= '0;
      gap_q  <= '0;
    end else begin
      edge_q <= edge_d;
      tmo_q  <= tmo_d;
      gap_q  <= gap_d;
    end
  end

  assign pass = !clr && osc_tick && (edge_q == cfg_edges - 1'b1);
  assign fail = !clr && !pass && (tmo_q == cfg_tmo - 1'b1);

  // R2: timeout and pass are exclusive outcomes
  p_pass_fail_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  // R10: a pass only ever happens on a tick
  p_pass_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> osc_tick);
endmodule

// File: rtl/rws_wake_decode.sv
module rws_wake_decode
  import rws_pkg::*;
(
  input  seq_st_e st,
  input  logic    irq_ext,
  input  logic    irq_int,
  input  logic    wake_tmr,
  output logic    wake
);
  always_comb begin
    unique case (st)
      ST_STOP:  wake = irq_ext | wake_tmr;
      ST_PSTOP: wake = irq_ext | wake_tmr | irq_int;
      ST_DOZE:  wake = irq_ext | irq_int;
      default:  wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/rst_wake_seq.sv
module rst_wake_seq
  import rws_pkg::*;
#(
  parameter int EDGE_W      = 8,
  parameter int TMO_W       = 16,
  parameter int GAP_MAX     = 8,
  parameter int EXT_MIN     = 2,
  parameter int STARTUP_CYC = 194
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_pulse,
  input  logic              lvr_pulse,
  input  logic              ext_rst_req,
  input  logic              osc_tick,
  input  logic              vreg_fpm,
  input  logic              lp_req,
  input  logic [1:0]        lp_sel,
  input  logic              irq_ext,
  input  logic              irq_int,
  input  logic              wake_tmr,
  input  logic              por_clr,
  input  logic [EDGE_W-1:0] cfg_edges,
  input  logic [TMO_W-1:0]  cfg_tmo,
  output logic              rst_int,
  output logic              clk_en,
  output logic              clk_sel_self,
  output logic              por_flag,
  output logic [NUM_ST-1:0] state_oh,
  output logic              seq_done
);
  localparam int SU_W = $clog2(STARTUP_CYC);
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_CYC - 1);

  seq_st_e         st_q, st_d;
  logic            in_rst_q, in_rst_d;
  logic            osc_ok_q, osc_ok_d;
  logic            sel_q, sel_d;
  logic            por_q, por_d;
  logic            wstop_q, wstop_d;
  logic            done_q, done_d;
  logic [SU_W-1:0] su_q, su_d;

  logic ext_qual, cq_pass, cq_fail, wake, cause_pl, cause_any, cq_clr;

  rws_ext_filter #(.EXT_MIN(EXT_MIN)) u_ext (
    .clk(clk), .rst_n(rst_n), .req(ext_rst_req), .qual(ext_qual)
  );

  assign cause_pl  = por_pulse | lvr_pulse;
  assign cause_any = cause_pl | ext_qual;
  assign cq_clr    = (st_q != ST_CQ) || cause_any;

  rws_clk_check #(.EDGE_W(EDGE_W), .TMO_W(TMO_W), .GAP_MAX(GAP_MAX)) u_cq (
    .clk(clk), .rst_n(rst_n), .clr(cq_clr), .osc_tick(osc_tick),
    .cfg_edges(cfg_edges), .cfg_tmo(cfg_tmo), .pass(cq_pass), .fail(cq_fail)
  );

  rws_wake_decode u_wake (
    .st(st_q), .irq_ext(irq_ext), .irq_int(irq_int), .wake_tmr(wake_tmr),
    .wake(wake)
  );

  // next-state process
  always_comb begin
    st_d     = st_q;
    in_rst_d = in_rst_q;
    osc_ok_d = osc_ok_q;
    sel_d    = sel_q;
    por_d    = por_q;
    wstop_d  = wstop_q;
    if (por_clr)   por_d = 1'b0;
    if (por_pulse) por_d = 1'b1;
    if (cause_pl) begin
      st_d     = ST_CQ;
      in_rst_d = 1'b1;
      osc_ok_d = 1'b0;
    end else if (ext_qual) begin
      in_rst_d = 1'b1;
      st_d     = osc_ok_q ? ST_SU : ST_CQ;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (lp_req) begin
            unique case (lp_sel)
              LP_STOP:  begin st_d = ST_STOP; osc_ok_d = 1'b0; end
              LP_PSTOP: st_d = ST_PSTOP;
              LP_DOZE:  st_d = ST_DOZE;
              default:  st_d = ST_RUN;
            endcase
          end
        end
        ST_CQ: begin
          if (cq_pass || cq_fail) begin
            osc_ok_d = cq_pass;
            sel_d    = cq_fail;
            st_d     = in_rst_q ? ST_SU : ST_RUN;
          end
        end
        ST_SU: begin
          if (su_q == SU_LAST) begin
            st_d     = ST_RUN;
            in_rst_d = 1'b0;
          end
        end
        ST_VREG: if (vreg_fpm) st_d = wstop_q ? ST_CQ : ST_RUN;
        ST_STOP: if (wake) begin st_d = ST_VREG; wstop_d = 1'b1; end
        ST_PSTOP: if (wake) begin st_d = ST_VREG; wstop_d = 1'b0; end
        ST_DOZE: if (wake) st_d = ST_RUN;
        default: st_d = ST_RUN;
      endcase
    end
    su_d   = (st_q == ST_SU && !cause_any) ? su_q + 1'b1 : '0;
    done_d = (st_q != ST_RUN) && (st_d == ST_RUN);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_CQ;
      in_rst_q <= 1'b1;
      osc_ok_q <= 1'b0;
      sel_q    <= 1'b0;
      por_q    <= 1'b1;
      wstop_q  <= 1'b0;
      done_q   <= 1'b0;
      su_q     <= '0;
    end else begin
      st_q     <= st_d;
      in_rst_q <= in_rst_d;
      osc_ok_q <= osc_ok_d;
      sel_q    <= sel_d;
      por_q    <= por_d;
      wstop_q  <= wstop_d;
      done_q   <= done_d;
      su_q     <= su_d;
    end
  end

  for (genvar g = 0; g < NUM_ST; g++) begin : g_oh
    assign state_oh[g] = (st_q == seq_st_e'(g));
  end

  assign rst_int      = in_rst_q;
  assign clk_en       = (st_q == ST_RUN) || (st_q == ST_SU);
  assign clk_sel_self = sel_q;
  assign por_flag     = por_q;
  assign seq_done     = done_q;

  // R8: reset is only released from a completed startup count
  p_rst_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rst_q) |-> ($past(st_q) == ST_SU) && ($past(su_q) == SU_LAST));
  // R4: stable oscillator lets an external reset skip the check
  p_ext_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_qual && !cause_pl && osc_ok_q) |=> (st_q == ST_SU));
  // R7: doze wake resumes in one cycle
  p_doze_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DOZE && wake && !cause_any) |=> (st_q == ST_RUN));
  // R6: pseudo-stop recovery never visits the clock check
  p_pstop_no_cq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VREG && !wstop_q && vreg_fpm && !cause_any) |=> (st_q == ST_RUN));
  // R9: flag only moves on a power-on or clear request
  p_por_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_pulse && !por_clr) |=> $stable(por_q));
  // R12: a reset cause overrides a wake
  p_cause_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_pl && wake) |=> (st_q == ST_CQ && in_rst_q));
endmodule

// File: tb/rst_wake_seq_tb_top.sv
module rst_wake_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n, por_pulse, lvr_pulse, ext_rst_req, osc_tick, vreg_fpm;
  logic lp_req, irq_ext, irq_int, wake_tmr, por_clr;
  logic [1:0] lp_sel;
  logic [7:0] cfg_edges;
  logic [15:0] cfg_tmo;
  logic rst_int, clk_en, clk_sel_self, por_flag, seq_done;
  logic [6:0] state_oh;
  int checks = 0, errors = 0;
  int osc_mode = 1;
  int osc_cnt = 0;

  always #10 clk = ~clk;

  rst_wake_seq dut_i (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .lvr_pulse(lvr_pulse),
    .ext_rst_req(ext_rst_req), .osc_tick(osc_tick), .vreg_fpm(vreg_fpm),
    .lp_req(lp_req), .lp_sel(lp_sel), .irq_ext(irq_ext), .irq_int(irq_int),
    .wake_tmr(wake_tmr), .por_clr(por_clr), .cfg_edges(cfg_edges),
    .cfg_tmo(cfg_tmo), .rst_int(rst_int), .clk_en(clk_en),
    .clk_sel_self(clk_sel_self), .por_flag(por_flag), .state_oh(state_oh),
    .seq_done(seq_done)
  );

  // oscillator edge model: 0 none, 1 every cycle, 2 every 10 cycles
  always @(negedge clk) begin
    osc_cnt <= (osc_cnt == 9) ? 0 : osc_cnt + 1;
    case (osc_mode)
      1: osc_tick <= 1'b1;
      2: osc_tick <= (osc_cnt == 0);
      default: osc_tick <= 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count sequence states until run is reached, sampling mid-cycle
  task automatic wait_run(output int cq_n, output int su_n, output int rst_seen,
                          output int su_bad);
    cq_n = 0; su_n = 0; rst_seen = 0; su_bad = 0;
    for (int i = 0; i < 3000; i++) begin
      if (state_oh[0]) break;
      if (state_oh[1]) cq_n++;
      if (state_oh[2]) begin
        su_n++;
        if (!(rst_int && clk_en)) su_bad++;
      end
      if (rst_int) rst_seen = 1;
      @(negedge clk);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic t_init;
    int c, s, r, b;
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    chk(state_oh == 7'b0000010, "R1 init state", state_oh, 2);
    chk(rst_int && !clk_en, "R1 init reset/clk", {rst_int, clk_en}, 2);
    chk(por_flag, "R9 init flag", por_flag, 1);
    wait_run(c, s, r, b);
    chk(c == 7, "R10 check length after init", c, 7);
    chk(s == 194 && b == 0, "R8 startup length", s, 194);
    chk(!rst_int && clk_en && seq_done, "R12 run and done", {rst_int, clk_en, seq_done}, 3);
    chk(!clk_sel_self, "R2 crystal selected", clk_sel_self, 0);
  endtask

  task automatic t_timeout;
    int c, s, r, b;
    osc_mode = 0; cfg_tmo = 50;
    pulse(por_pulse);
    wait_run(c, s, r, b);
    chk(c == 50, "R2 timeout length", c, 50);
    chk(clk_sel_self, "R2 self clock", clk_sel_self, 1);
    chk(s == 194, "R8 startup after timeout", s, 194);
  endtask

  task automatic t_gap;
    int c, s, r, b;
    osc_mode = 2; cfg_tmo = 200;
    pulse(lvr_pulse);
    wait_run(c, s, r, b);
    chk(c == 200 && clk_sel_self, "R10 sparse edges time out", c, 200);
  endtask

  task automatic t_ext;
    int c, s, r, b;
    osc_mode = 1; cfg_tmo = 1000;
    ext_rst_req = 1'b1; cyc(2); ext_rst_req = 1'b0;
    chk(state_oh[1] && rst_int, "R4 ext without stable osc runs check", state_oh, 2);
    wait_run(c, s, r, b);
    chk(c == 8 && !clk_sel_self, "R10 check passes on 8th edge", c, 8);
    pulse(ext_rst_req); cyc(4);
    chk(state_oh[0] && !rst_int, "R3 short pulse ignored", state_oh, 1);
    ext_rst_req = 1'b1; cyc(2); ext_rst_req = 1'b0;
    chk(state_oh[2] && rst_int, "R3 R4 ext skips check", state_oh, 4);
    wait_run(c, s, r, b);
    chk(c == 0 && s == 194, "R4 startup only", s, 194);
  endtask

  task automatic t_flag;
    int c, s, r, b;
    pulse(por_clr); cyc(1);
    chk(!por_flag, "R9 cleared", por_flag, 0);
    pulse(lvr_pulse);
    chk(state_oh[1] && rst_int && !clk_en, "R1 lvr check", state_oh, 2);
    wait_run(c, s, r, b);
    chk(!por_flag, "R9 lvr keeps flag", por_flag, 0);
  endtask

  task automatic t_stop;
    int c, s, r, b;
    lp_sel = 2'd1; pulse(lp_req); vreg_fpm = 1'b0;
    chk(state_oh[4], "R11 stop entered", state_oh, 16);
    pulse(irq_int); cyc(1);
    chk(state_oh[4], "R11 internal irq ignored in stop", state_oh, 16);
    pulse(irq_ext); cyc(2);
    chk(state_oh[3] && !clk_en, "R5 regulator wait", state_oh, 8);
    pulse(wake_tmr); cyc(1);
    chk(state_oh[3], "R11 wake ignored in regulator wait", state_oh, 8);
    vreg_fpm = 1'b1; cyc(1);
    chk(state_oh[1], "R5 check after regulator", state_oh, 2);
    wait_run(c, s, r, b);
    chk(c == 8 && s == 0 && r == 0 && seq_done, "R5 stop recovery", c, 8);
  endtask

  task automatic t_pstop;
    lp_sel = 2'd2; pulse(lp_req); vreg_fpm = 1'b0;
    pulse(irq_int); cyc(2);
    chk(state_oh[3], "R6 regulator wait", state_oh, 8);
    vreg_fpm = 1'b1; cyc(1);
    chk(state_oh[0] && seq_done && !rst_int, "R6 run without check", state_oh, 1);
  endtask

  task automatic t_doze;
    lp_sel = 2'd3; pulse(lp_req);
    pulse(wake_tmr); cyc(1);
    chk(state_oh[6], "R11 timer ignored in doze", state_oh, 64);
    pulse(irq_int);
    chk(state_oh[0] && seq_done && clk_en, "R7 doze resumes at once", state_oh, 1);
  endtask

  task automatic t_clash;
    int c, s, r, b;
    lp_sel = 2'd1; pulse(lp_req);
    irq_ext = 1'b1; lvr_pulse = 1'b1; cyc(1);
    irq_ext = 1'b0; lvr_pulse = 1'b0;
    chk(state_oh[1] && rst_int, "R12 reset wins over wake", state_oh, 2);
    wait_run(c, s, r, b);
    chk(s == 194, "R12 full startup after clash", s, 194);
    pulse(por_pulse);
    chk(por_flag, "R9 por sets flag", por_flag, 1);
    wait_run(c, s, r, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_pulse = 0; lvr_pulse = 0; ext_rst_req = 0; vreg_fpm = 1;
    lp_req = 0; lp_sel = 0; irq_ext = 0; irq_int = 0; wake_tmr = 0; por_clr = 0;
    cfg_edges = 8'd8; cfg_tmo = 16'd1000; osc_tick = 0;
    @(negedge clk);
    t_init;
    t_timeout;
    t_gap;
    t_ext;
    t_flag;
    t_stop;
    t_pstop;
    t_doze;
    t_clash;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule